// File: doc/BRIEF.md
# Display Memory DRAM Controller With Selectable Byte-Lane Strobing

This block drives a 16-bit-wide display DRAM through a 10-bit multiplexed address bus. A single internal requester asks for one word or byte access at a time. The block places the row half of the address on the bus and drops the row strobe. After a programmable delay it places the column half and fires the column and write strobes. It holds them, releases everything, and respects a precharge interval before the next cycle. A built-in interval timer schedules refresh cycles of the CAS-before-RAS kind. These slot in between requester accesses and win whenever both are due together.

Three strobe pins change meaning with the `lane_mode` input, which is sampled at the start of each cycle:

- **Split-CAS mode** (`lane_mode` = 0): two column strobes, one per byte lane, share one write enable.
- **Split-WE mode** (`lane_mode` = 1): one column strobe is shared by both lanes, and each lane has its own write enable.

Top module: `vdram_ctrl`

## Requirements
- R1: While and right after `rst` is high, `ras_n`, `strobe_u_n`, `strobe_l_n` and `strobe_w_n` are 1, and `rdy` and `dq_oe` are 0.
- R2: An access drives `req_addr[19:10]` on `dram_addr` when `ras_n` falls. It drives `req_addr[9:0]` when the column strobe falls, exactly T_RCD cycles later.
- R3: With `lane_mode`=0, `strobe_u_n` is the column strobe of the upper byte `[15:8]`, `strobe_l_n` is that of the lower byte `[7:0]`, and `strobe_w_n` is a write enable common to both. A read fires both column strobes. A write fires the column strobe of lane k only when `req_be[k]` is 1 (`req_be[1]` upper, `req_be[0]` lower).
- R4: With `lane_mode`=1, `strobe_u_n` is the only column strobe and fires on every access. `strobe_l_n` is the lower-byte write enable and `strobe_w_n` the upper-byte write enable. Each fires only on a write whose `req_be` bit for that lane is 1.
- R5: A write enable is low only while `dq_oe` is 1 and `dq_out` holds `req_wdata`. Only the enabled lanes of the addressed word change.
- R6: A read returns all 16 bits of the addressed word on `rd_data` in the cycle `rdy` is 1.
- R7: `rdy` is 1 for exactly one cycle per access. When no refresh intervenes, it rises 1+T_RCD+T_CAS clock edges after the first edge that samples `req`. `req` and its fields are held until then.
- R8: One refresh is scheduled every REF_INTERVAL cycles. It lowers the column strobe(s) one cycle before `ras_n` falls, and keeps all write enables high.
- R9: A pending refresh is served before a request seen in the same idle cycle. An access delayed by a refresh finishes within 3+T_RCD+2*T_CAS+T_RP edges.
- R10: Once `ras_n` rises, it stays high for at least T_RP cycles.
- R11: A write with `req_be`=00 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_mode | input | 1 | 0 split-CAS, 1 split-WE; sampled at cycle start |
| req | input | 1 | Access request, held until `rdy` |
| req_wr | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Row in [19:10], column in [9:0] |
| req_be | input | 2 | Byte enables for writes: [1] upper, [0] lower |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with `rdy` |
| dram_addr | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| strobe_u_n | output | 1 | Upper column strobe (mode 0) or sole column strobe (mode 1) |
| strobe_l_n | output | 1 | Lower column strobe (mode 0) or lower write enable (mode 1) |
| strobe_w_n | output | 1 | Shared write enable (mode 0) or upper write enable (mode 1) |
| dq_out | output | 16 | Data driven to the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data returned by the DRAM |

## Verification
On every cycle, the assertions check:
- `rdy` is a single-cycle pulse.
- The column-before-row ordering and quiet write enables of refresh.
- That no write enable falls without the data bus driven.
- The precharge gap after the row strobe rises.
- That a pending refresh beats a waiting request.

Only the bench scenarios, run against a behavioural DRAM model, can show three further things:
- The right bytes land in memory under each lane mode and byte-enable pattern, including the empty pattern.
- Reads return the stored word.
- The refresh count over a long idle stretch matches the interval, and the exact access latency holds.

// File: rtl/vdram_pkg.sv
package vdram_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW,
    S_COL,
    S_PRE,
    S_REF_C,
    S_REF_R
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_REFRESH
  } lane_op_t;

  typedef struct packed {
    logic a_n;  // upper CAS / sole CAS
    logic b_n;  // lower CAS / lower WE
    logic c_n;  // shared WE / upper WE
  } strobe_t;

  localparam logic MODE_SPLIT_CAS = 1'b0;
  localparam logic MODE_SPLIT_WE  = 1'b1;
endpackage

// File: rtl/vdram_refresh_timer.sv
module vdram_refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] tcnt;
  logic          wrap;

  assign wrap = (tcnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (wrap) tcnt <= '0;
      else      tcnt <= tcnt + 1'b1;
      if (ack)  pend <= 1'b0;
      if (wrap) pend <= 1'b1;
    end
  end

  // R8: a scheduled refresh stays pending until the sequencer takes it
  a_r8_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);

  // R8: the interval expiry always leaves a refresh pending
  a_r8_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pend);
endmodule

// File: rtl/vdram_lane_map.sv
module vdram_lane_map
  import vdram_pkg::*;
(
  input  logic       mode,
  input  lane_op_t   op,
  input  logic [1:0] be,
  output strobe_t    stb
);
  always_comb begin
    stb = '1;
    case (op)
      OP_REFRESH: begin
        stb.a_n = 1'b0;
        stb.b_n = (mode == MODE_SPLIT_WE);
      end
      OP_READ: begin
        stb.a_n = 1'b0;
        stb.b_n = (mode == MODE_SPLIT_WE);
      end
      OP_WRITE: begin
        if (mode == MODE_SPLIT_WE) begin
          stb.a_n = 1'b0;
          stb.b_n = ~be[0];
          stb.c_n = ~be[1];
        end else begin
          stb.a_n = ~be[1];
          stb.b_n = ~be[0];
          stb.c_n = 1'b0;
        end
      end
      default: stb = '1;
    endcase
  end
endmodule

// File: rtl/vdram_sequencer.sv
module vdram_sequencer
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lane_mode,
  input  logic                  req,
  input  logic                  req_wr,
  input  logic [2*ADDR_W-1:0]   req_addr,
  input  logic [1:0]            req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  ref_pend,
  output logic                  ref_ack,
  output logic                  rdy,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W-1:0]     dram_addr,
  output logic                  ras_n,
  output logic                  strobe_u_n,
  output logic                  strobe_l_n,
  output logic                  strobe_w_n,
  output logic [DATA_W-1:0]     dq_out,
  output logic                  dq_oe,
  input  logic [DATA_W-1:0]     dq_in
);
  localparam int MAXD = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                        : ((T_CAS > T_RP) ? T_CAS : T_RP);
  localparam int CW   = $clog2(MAXD + 1);

  seq_state_t        state;
  logic [CW-1:0]     cnt;
  logic              mode_q;
  logic              wr_q;
  logic [1:0]        be_q;
  logic [ADDR_W-1:0] col_q;
  strobe_t           stb_q;
  strobe_t           map_stb;
  logic              map_mode;
  lane_op_t          map_op;

  assign map_mode = (state == S_IDLE) ? lane_mode : mode_q;
  assign map_op   = (state == S_IDLE) ? OP_REFRESH : (wr_q ? OP_WRITE : OP_READ);
  assign ref_ack  = (state == S_IDLE) && ref_pend;

  vdram_lane_map i_map (
    .mode (map_mode),
    .op   (map_op),
    .be   (be_q),
    .stb  (map_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mode_q    <= 1'b0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      col_q     <= '0;
      stb_q     <= '1;
      ras_n     <= 1'b1;
      rdy       <= 1'b0;
      rd_data   <= '0;
      dram_addr <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
    end else begin
      rdy <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend) begin
            mode_q <= lane_mode;
            stb_q  <= map_stb;
            state  <= S_REF_C;
          end else if (req) begin
            mode_q    <= lane_mode;
            wr_q      <= req_wr;
            be_q      <= req_be;
            col_q     <= req_addr[ADDR_W-1:0];
            dram_addr <= req_addr[2*ADDR_W-1:ADDR_W];
            dq_out    <= req_wdata;
            ras_n     <= 1'b0;
            state     <= S_ROW;
          end
        end
        S_ROW: begin
          if (cnt == CW'(T_RCD - 1)) begin
            dram_addr <= col_q;
            stb_q     <= map_stb;
            dq_oe     <= wr_q;
            cnt       <= '0;
            state     <= S_COL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_COL: begin
          if (cnt == CW'(T_CAS - 1)) begin
            if (!wr_q) rd_data <= dq_in;
            rdy   <= 1'b1;
            ras_n <= 1'b1;
            stb_q <= '1;
            dq_oe <= 1'b0;
            cnt   <= '0;
            state <= S_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == CW'(T_RP - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REF_C: begin
          ras_n <= 1'b0;
          cnt   <= '0;
          state <= S_REF_R;
        end
        S_REF_R: begin
          if (cnt == CW'(T_CAS - 1)) begin
            ras_n <= 1'b1;
            stb_q <= '1;
            cnt   <= '0;
            state <= S_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe_u_n = stb_q.a_n;
  assign strobe_l_n = stb_q.b_n;
  assign strobe_w_n = stb_q.c_n;

  // R1: quiet bus in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (ras_n && stb_q == 3'b111 && !rdy && !dq_oe));

  // R7: completion is a single-cycle pulse
  a_r7_rdy_pulse: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  // R8: refresh drops CAS a cycle before RAS, write enables stay high
  a_r8_cbr_order: assert property (@(posedge clk) disable iff (rst)
    (state == S_REF_R && $fell(ras_n)) |-> ($past(!stb_q.a_n) && stb_q.c_n));

  // R5: the shared/upper write enable only falls with the data bus driven
  a_r5_we_with_data: assert property (@(posedge clk) disable iff (rst)
    !stb_q.c_n |-> dq_oe);

  // R4: in split-WE mode the lower write enable comes with CAS and driven data
  a_r4_lower_we: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !stb_q.b_n) |-> (!stb_q.a_n && dq_oe));

  // R2: a column strobe during an access falls only after RAS is already low
  a_r2_ras_first: assert property (@(posedge clk) disable iff (rst)
    (!stb_q.a_n && !ras_n && $past(stb_q.a_n)) |-> $past(!ras_n));

  // R10: after RAS rises it is held high
  a_r10_precharge: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n);

  // R9: a pending refresh is taken ahead of any request
  a_r9_refresh_first: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && ref_pend) |=> (state == S_REF_C && ras_n));
endmodule

// File: rtl/vdram_ctrl.sv
module vdram_ctrl #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lane_mode,
  input  logic                req,
  input  logic                req_wr,
  input  logic [2*ADDR_W-1:0] req_addr,
  input  logic [1:0]          req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rdy,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   dram_addr,
  output logic                ras_n,
  output logic                strobe_u_n,
  output logic                strobe_l_n,
  output logic                strobe_w_n,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in
);
  logic ref_pend;
  logic ref_ack;

  vdram_refresh_timer #(
    .INTERVAL (REF_INTERVAL)
  ) i_timer (
    .clk  (clk),
    .rst  (rst),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  vdram_sequencer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .lane_mode  (lane_mode),
    .req        (req),
    .req_wr     (req_wr),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .rdy        (rdy),
    .rd_data    (rd_data),
    .dram_addr  (dram_addr),
    .ras_n      (ras_n),
    .strobe_u_n (strobe_u_n),
    .strobe_l_n (strobe_l_n),
    .strobe_w_n (strobe_w_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .dq_in      (dq_in)
  );
endmodule

// File: tb/test_vdram_ctrl.sv
`timescale 1ns/1ps
module test_vdram_ctrl;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_RP   = 2;
  localparam int REF    = 64;
  localparam int LAT0   = 1 + T_RCD + T_CAS;
  localparam int LATMAX = LAT0 + 2 + T_CAS + T_RP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lane_mode = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rdy;
  logic [15:0] rd_data;
  logic [9:0]  dram_addr;
  logic        ras_n, strobe_u_n, strobe_l_n, strobe_w_n;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [15:0] dq_in = '0;

  always #10 clk = ~clk;

  vdram_ctrl i_vdram_ctrl (
    .clk(clk), .rst(rst), .lane_mode(lane_mode), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rdy(rdy),
    .rd_data(rd_data), .dram_addr(dram_addr), .ras_n(ras_n),
    .strobe_u_n(strobe_u_n), .strobe_l_n(strobe_l_n), .strobe_w_n(strobe_w_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  // Behavioural DRAM model: 8 rows x 16 columns of the address space
  logic [15:0] mem [128];
  logic [15:0] shadow [128];
  logic [9:0]  m_row = '0, m_col = '0;
  int ref_cnt = 0, last_ref_cyc = -1000, ras_fall_cyc = 0;
  int proto_err = 0, rcd_bad = 0, run = 1000, min_run = 1000;
  bit s_cu, s_cl, s_wu, s_wl;
  logic prev_ras = 1'b1, prev_a = 1'b1, prev_b = 1'b1;

  function automatic int idx_of(input logic [9:0] r, input logic [9:0] c);
    return int'({r[2:0], c[3:0]});
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit fell_ras = prev_ras && !ras_n;
      automatic bit a_fall = prev_a && !strobe_u_n;
      automatic bit b_fall = prev_b && !strobe_l_n;
      if (fell_ras) begin
        if (run < min_run) min_run = run;
        run = 0;
        if (!strobe_u_n) begin
          ref_cnt++;
          last_ref_cyc = cyc;
          if (!strobe_w_n || (lane_mode && !strobe_l_n)) proto_err++;
        end else begin
          m_row = dram_addr;
          ras_fall_cyc = cyc;
        end
      end
      if (ras_n) run++;
      if (!ras_n && !fell_ras) begin
        if (!lane_mode) begin
          if (a_fall || b_fall) begin
            m_col = dram_addr;
            if (cyc - ras_fall_cyc != T_RCD) rcd_bad++;
          end
          if (a_fall) begin
            s_cu = 1;
            if (!strobe_w_n) begin
              mem[idx_of(m_row, m_col)][15:8] = dq_out[15:8];
              s_wu = 1;
            end
          end
          if (b_fall) begin
            s_cl = 1;
            if (!strobe_w_n) begin
              mem[idx_of(m_row, m_col)][7:0] = dq_out[7:0];
              s_wl = 1;
            end
          end
        end else if (a_fall) begin
          m_col = dram_addr;
          if (cyc - ras_fall_cyc != T_RCD) rcd_bad++;
          s_cu = 1;
          if (!strobe_l_n) begin
            mem[idx_of(m_row, m_col)][7:0] = dq_out[7:0];
            s_wl = 1;
          end
          if (!strobe_w_n) begin
            mem[idx_of(m_row, m_col)][15:8] = dq_out[15:8];
            s_wu = 1;
          end
        end
      end
      if (!strobe_w_n && !dq_oe) proto_err++;
      if (lane_mode && !strobe_l_n && !dq_oe) proto_err++;
      dq_in = mem[idx_of(m_row, m_col)];
      prev_ras = ras_n;
      prev_a = strobe_u_n;
      prev_b = strobe_l_n;
    end
  end

  task automatic do_access(input logic wr, input logic [2:0] row, input logic [3:0] col,
                           input logic [1:0] be, input logic [15:0] wd);
    int lat, rc0, q, ix;
    bit clean, any_cas;
    logic [15:0] got;
    @(negedge clk);
    req = 1'b1;
    req_wr = wr;
    req_addr = {7'd0, row, 6'd0, col};
    req_be = be;
    req_wdata = wd;
    s_cu = 0; s_cl = 0; s_wu = 0; s_wl = 0;
    rc0 = ref_cnt;
    q = cyc + 1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rdy && lat < 40);
    got = rd_data;
    req = 1'b0;
    clean = (ref_cnt == rc0) && (q - last_ref_cyc > T_CAS + T_RP);
    if (clean) chk(lat == LAT0, "R7 latency", lat, LAT0);
    else       chk(lat <= LATMAX, "R9 refresh-delayed latency", lat, LATMAX);
    ix = int'({row, col});
    any_cas = !wr || lane_mode || (be != 2'b00);
    if (any_cas) chk(m_row == 10'(row) && m_col == 10'(col), "R2 row/col address",
                     {m_row, m_col}, {10'(row), 10'(col)});
    if (wr) begin
      shadow[ix] = merge(shadow[ix], wd, be);
      chk({s_wu, s_wl} == be, lane_mode ? "R4 write lanes" : "R3 write lanes", {s_wu, s_wl}, be);
      if (!lane_mode) chk({s_cu, s_cl} == be, "R3 write CAS lanes", {s_cu, s_cl}, be);
      else            chk(s_cu, "R4 sole CAS on write", s_cu, 1);
    end else begin
      chk(got == shadow[ix], "R6 read data", got, shadow[ix]);
      chk({s_wu, s_wl} == 2'b00, "R5 no write on read", {s_wu, s_wl}, 0);
      if (!lane_mode) chk({s_cu, s_cl} == 2'b11, "R3 read CAS both", {s_cu, s_cl}, 3);
      else            chk(s_cu, "R4 sole CAS on read", s_cu, 1);
    end
    @(negedge clk);
    chk(!rdy, "R7 rdy single pulse", rdy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic directed(input logic m);
    lane_mode = m;
    do_access(1, 3'd5, 4'd9, 2'b11, 16'hA5C3);
    do_access(0, 3'd5, 4'd9, 2'b00, 16'h0);
    chk(shadow[int'({3'd5, 4'd9})] == 16'hA5C3, "R5 full write", shadow[int'({3'd5, 4'd9})], 16'hA5C3);
    do_access(1, 3'd5, 4'd9, 2'b10, 16'h11EE);
    do_access(0, 3'd5, 4'd9, 2'b00, 16'h0);
    chk(mem[int'({3'd5, 4'd9})] == 16'h11C3, "R5 upper-only write", mem[int'({3'd5, 4'd9})], 16'h11C3);
    do_access(1, 3'd5, 4'd9, 2'b01, 16'h2277);
    do_access(0, 3'd5, 4'd9, 2'b00, 16'h0);
    chk(mem[int'({3'd5, 4'd9})] == 16'h1177, "R5 lower-only write", mem[int'({3'd5, 4'd9})], 16'h1177);
    do_access(1, 3'd5, 4'd9, 2'b00, 16'hFFFF);
    do_access(0, 3'd5, 4'd9, 2'b00, 16'h0);
    chk(mem[int'({3'd5, 4'd9})] == 16'h1177, "R11 empty byte enables", mem[int'({3'd5, 4'd9})], 16'h1177);
  endtask

  task automatic random_run(input logic m, input int n);
    lane_mode = m;
    for (int i = 0; i < n; i++) begin
      automatic logic wr = 1'($urandom % 2);
      automatic logic [2:0] r = 3'($urandom % 8);
      automatic logic [3:0] c = 4'($urandom % 16);
      automatic logic [1:0] b = 2'($urandom % 4);
      automatic logic [15:0] d = 16'($urandom);
      do_access(wr, r, c, b, d);
    end
  endtask

  initial begin
    int rc0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(ras_n && strobe_u_n && strobe_l_n && strobe_w_n, "R1 strobes in reset",
        {ras_n, strobe_u_n, strobe_l_n, strobe_w_n}, 4'hF);
    chk(!rdy && !dq_oe, "R1 rdy/oe in reset", {rdy, dq_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && strobe_u_n && strobe_l_n && strobe_w_n && !rdy && !dq_oe,
        "R1 quiet after reset", {ras_n, strobe_u_n, strobe_l_n, strobe_w_n, rdy, dq_oe}, 6'h3C);

    rc0 = ref_cnt;
    repeat (20 * REF) @(negedge clk);
    chk((ref_cnt - rc0) >= 19 && (ref_cnt - rc0) <= 21, "R8 refresh interval", ref_cnt - rc0, 20);

    directed(1'b0);
    random_run(1'b0, 150);
    directed(1'b1);
    random_run(1'b1, 150);
    lane_mode = 1'b0;
    random_run(1'b0, 40);

    rc0 = ref_cnt;
    repeat (10 * REF) @(negedge clk);
    chk((ref_cnt - rc0) >= 9 && (ref_cnt - rc0) <= 11, "R8 refresh interval after traffic", ref_cnt - rc0, 10);
    chk(proto_err == 0, "R5/R8 write enable protocol", proto_err, 0);
    chk(rcd_bad == 0, "R2 RAS-to-CAS spacing", rcd_bad, 0);
    chk(min_run >= T_RP, "R10 precharge length", min_run, T_RP);
    finish_up();
  end
endmodule